// File: doc/BRIEF.md
# Indirect Register Window I/O Decoder

This block is the host-side I/O slave of a network controller attached to an ISA-style bus. It compares the 16-bit I/O address against a parameterised base, detects the start of each read or write strobe, and turns every accepted bus cycle into exactly one internal action. A few fixed ports reach frame data, the transmit command, the transmit length and the interrupt status queue directly. Everything else inside the controller is reached indirectly. The host loads a pointer register with a word address and then reads or writes a data-port pair.

The pointer holds a 12-bit address field, three read-only bits that always read back as 011b, and a mode bit in bit 15. When the mode bit is set, every data-port word access moves the address field on by 2. This lets a host stream through consecutive registers without reloading the pointer. A 32-bit access uses data port 0 for the low word and data port 1 for the high word. The block drives a registered internal address, read and write pulses, and write data, and it returns the internal read data to the host one cycle after the read pulse.

Top module: `iowin_top`

## Requirements
- R1: A bus cycle is accepted only while `io_addr_dis` is low and `io_addr[15:4]` equals `BASE_ADDR[15:4]`. It takes effect on the first clock where `io_rd_n` or `io_wr_n` is sampled low after being high. A strobe held low for several clocks causes exactly one action. A write strobe takes priority over a read strobe.
- R2: After reset the pointer reads 3000h, `tx_cmd`, `tx_len` and `io_rdata` are 0, and no pulse output is high.
- R3: Pointer bits 14..12 always read as 011b. Values written to those bits are discarded.
- R4: The pointer sits at offsets Ah/Bh. `io_be[0]` enables writing bits 7..0, and `io_be[1]` enables writing bits 11..8 and the mode bit 15.
- R5: With the mode bit 0, an access to data port 0 (offset Ch) drives `reg_addr` equal to the pointer field and leaves the pointer unchanged.
- R6: With the mode bit 1, each accepted data-port access adds 2 to the 12-bit field. The field wraps from FFEh to 000h, and bits 15..12 are untouched.
- R7: Data port 1 (offset Eh) reaches field+2. In auto mode, a port 1 access that directly follows a port 0 access reaches the already advanced field. A port 0/port 1 pair therefore touches P and P+2 and leaves P+4.
- R8: A data-port read pulses `reg_rd` for one cycle. `io_rdata` takes the value of `reg_rdata` on the clock after the pulse and holds it until the next accepted read.
- R9: Writes to offsets 4h and 6h load `tx_cmd` and `tx_len`. Reads of those offsets return the last written values.
- R10: Offset 0h pulses `frame_rd` or `frame_wr`, and a read returns `frame_rdata`. Offset 8h reads pulse `isq_rd` and return `isq_rdata`. Write data appears on `wr_data` with the write pulse.
- R11: Offset 2h is unmapped. Accesses to it produce no pulse, and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Host I/O address |
| io_addr_dis | input | 1 | High marks a non-I/O (DMA) address phase; cycle ignored |
| io_rd_n | input | 1 | Read strobe, active low |
| io_wr_n | input | 1 | Write strobe, active low |
| io_be | input | 2 | Byte-lane enables for pointer writes |
| io_wdata | input | 16 | Host write data |
| io_rdata | output | 16 | Host read data |
| reg_addr | output | 12 | Internal register word address |
| reg_rd | output | 1 | Internal register read pulse |
| reg_wr | output | 1 | Internal register write pulse |
| wr_data | output | 16 | Write data for internal targets |
| reg_rdata | input | 16 | Internal register read data |
| frame_rd | output | 1 | Frame data read pulse |
| frame_wr | output | 1 | Frame data write pulse |
| frame_rdata | input | 16 | Frame data read value |
| isq_rd | output | 1 | Interrupt status queue read pulse |
| isq_rdata | input | 16 | Interrupt status queue value |
| tx_cmd | output | 16 | Last written transmit command |
| tx_len | output | 16 | Last written transmit length |

## Verification
The hardest state to reach is the auto-increment pair. Port 1 must reuse the already advanced field only when it directly follows a port 0 access, and the field must wrap at 12 bits while the mode and constant bits survive. The stimulus gets there through the ports alone. It loads the pointer with FFEh in auto mode, performs a data write that wraps the field, then runs a port 0/port 1 pair followed by a standalone port 1 access. After each step it reads the pointer back to confirm the new value. Rejected cycles are proven to have no effect in the same way: an auto-mode data access is attempted with a foreign base or with the address-disable high, and the pointer is then read back unchanged.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  // Word offset inside the 16-byte window (address bits 3..1)
  typedef enum logic [2:0] {
    P_FRAME = 3'd0,
    P_NONE  = 3'd1,
    P_TXCMD = 3'd2,
    P_TXLEN = 3'd3,
    P_ISQ   = 3'd4,
    P_PTR   = 3'd5,
    P_DATA0 = 3'd6,
    P_DATA1 = 3'd7
  } port_e;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_REG,
    SRC_FRAME,
    SRC_ISQ,
    SRC_PTR,
    SRC_TXCMD,
    SRC_TXLEN
  } rsrc_e;

endpackage

// File: rtl/iowin_decode.sv
module iowin_decode
  import iowin_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          OFS_W     = 4,
  parameter logic [AW-1:0] BASE_ADDR = 16'h0300
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] io_addr,
  input  logic          io_addr_dis,
  input  logic          io_rd_n,
  input  logic          io_wr_n,
  output logic          rd_go,
  output logic          wr_go,
  output port_e         port
);

  logic rd_q, wr_q, hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= ~io_rd_n;
      wr_q <= ~io_wr_n;
    end
  end

  assign hit   = ~io_addr_dis && (io_addr[AW-1:OFS_W] == BASE_ADDR[AW-1:OFS_W]);
  assign wr_go = hit && ~io_wr_n && ~wr_q;
  assign rd_go = hit && ~io_rd_n && ~rd_q && ~wr_go;
  assign port  = port_e'(io_addr[OFS_W-1:1]);

  // R1: a held strobe yields one action only
  a_r1_one_read: assert property (@(posedge clk) disable iff (rst) rd_go |=> !rd_go);
  a_r1_one_write: assert property (@(posedge clk) disable iff (rst) wr_go |=> !wr_go);

endmodule

// File: rtl/iowin_ptr.sv
module iowin_ptr #(
  parameter int PTR_W   = 16,
  parameter int FIELD_W = 12,
  parameter int STEP    = 2,
  parameter logic [PTR_W-FIELD_W-2:0] RO_VAL = 3'b011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [PTR_W/8-1:0] be,
  input  logic [PTR_W-1:0]   wdata,
  input  logic               step_en,
  output logic               mode,
  output logic [FIELD_W-1:0] field,
  output logic [PTR_W-1:0]   ptr_val
);

  localparam int MODE_LANE = (PTR_W - 1) / 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= 1'b0;
      field <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < FIELD_W; i++)
        if (be[i/8]) field[i] <= wdata[i];
      if (be[MODE_LANE]) mode <= wdata[PTR_W-1];
    end else if (step_en && mode) begin
      field <= field + FIELD_W'(STEP);
    end
  end

  assign ptr_val = {mode, RO_VAL, field};

  // R2: pointer value right after reset
  a_r2_ptr_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode == 1'b0 && field == '0));
  // R5: fixed mode keeps the pointer
  a_r5_fixed_hold: assert property (@(posedge clk) disable iff (rst)
    (step_en && !wr_en && !mode) |=> ($stable(field) && $stable(mode)));
  // R6: auto mode steps by STEP with 12-bit wrap, mode kept
  a_r6_auto_step: assert property (@(posedge clk) disable iff (rst)
    (step_en && !wr_en && mode) |=> (field == $past(field) + FIELD_W'(STEP) && mode));

endmodule

// File: rtl/iowin_rdmux.sv
module iowin_rdmux
  import iowin_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pend,
  input  rsrc_e         sel,
  input  logic [DW-1:0] src_reg,
  input  logic [DW-1:0] src_frame,
  input  logic [DW-1:0] src_isq,
  input  logic [DW-1:0] src_ptr,
  input  logic [DW-1:0] src_cmd,
  input  logic [DW-1:0] src_len,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] nx;

  always_comb begin
    unique case (sel)
      SRC_REG:   nx = src_reg;
      SRC_FRAME: nx = src_frame;
      SRC_ISQ:   nx = src_isq;
      SRC_PTR:   nx = src_ptr;
      SRC_TXCMD: nx = src_cmd;
      SRC_TXLEN: nx = src_len;
      default:   nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata <= '0;
    else if (pend) rdata <= nx;
  end

endmodule

// File: rtl/iowin_top.sv
module iowin_top
  import iowin_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h0300,
  parameter int          FIELD_W   = 12,
  parameter int          STEP      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        io_addr,
  input  logic               io_addr_dis,
  input  logic               io_rd_n,
  input  logic               io_wr_n,
  input  logic [1:0]         io_be,
  input  logic [15:0]        io_wdata,
  output logic [15:0]        io_rdata,
  output logic [FIELD_W-1:0] reg_addr,
  output logic               reg_rd,
  output logic               reg_wr,
  output logic [15:0]        wr_data,
  input  logic [15:0]        reg_rdata,
  output logic               frame_rd,
  output logic               frame_wr,
  input  logic [15:0]        frame_rdata,
  output logic               isq_rd,
  input  logic [15:0]        isq_rdata,
  output logic [15:0]        tx_cmd,
  output logic [15:0]        tx_len
);

  localparam int DW    = 16;
  localparam int PTR_W = 16;
  localparam logic [PTR_W-FIELD_W-2:0] RO_VAL = 3'b011;

  logic               rd_go, wr_go, go, data_acc, pair_open, mode, rd_pend;
  port_e              port;
  rsrc_e              rsel_nx, rsel;
  logic [FIELD_W-1:0] field, tgt_addr;
  logic [PTR_W-1:0]   ptr_val;

  iowin_decode #(.AW(16), .OFS_W(4), .BASE_ADDR(BASE_ADDR)) u_dec (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_addr_dis(io_addr_dis),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .rd_go(rd_go), .wr_go(wr_go), .port(port)
  );

  assign go       = rd_go || wr_go;
  assign data_acc = go && (port == P_DATA0 || port == P_DATA1);
  assign tgt_addr = (port == P_DATA1 && !pair_open) ? field + FIELD_W'(STEP) : field;

  iowin_ptr #(.PTR_W(PTR_W), .FIELD_W(FIELD_W), .STEP(STEP), .RO_VAL(RO_VAL)) u_ptr (
    .clk(clk), .rst(rst), .wr_en(wr_go && port == P_PTR), .be(io_be),
    .wdata(io_wdata), .step_en(data_acc), .mode(mode), .field(field),
    .ptr_val(ptr_val)
  );

  always_comb begin
    case (port)
      P_FRAME:        rsel_nx = SRC_FRAME;
      P_TXCMD:        rsel_nx = SRC_TXCMD;
      P_TXLEN:        rsel_nx = SRC_TXLEN;
      P_ISQ:          rsel_nx = SRC_ISQ;
      P_PTR:          rsel_nx = SRC_PTR;
      P_DATA0,
      P_DATA1:        rsel_nx = SRC_REG;
      default:        rsel_nx = SRC_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      frame_rd  <= 1'b0;
      frame_wr  <= 1'b0;
      isq_rd    <= 1'b0;
      rd_pend   <= 1'b0;
      pair_open <= 1'b0;
      rsel      <= SRC_ZERO;
      reg_addr  <= '0;
      wr_data   <= '0;
      tx_cmd    <= '0;
      tx_len    <= '0;
    end else begin
      reg_rd   <= rd_go && data_acc;
      reg_wr   <= wr_go && data_acc;
      frame_rd <= rd_go && port == P_FRAME;
      frame_wr <= wr_go && port == P_FRAME;
      isq_rd   <= rd_go && port == P_ISQ;
      rd_pend  <= rd_go;
      if (rd_go)    rsel      <= rsel_nx;
      if (go)       pair_open <= (port == P_DATA0) && mode;
      if (data_acc) reg_addr  <= tgt_addr;
      if (wr_go)    wr_data   <= io_wdata;
      if (wr_go && port == P_TXCMD) tx_cmd <= io_wdata;
      if (wr_go && port == P_TXLEN) tx_len <= io_wdata;
    end
  end

  iowin_rdmux #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .pend(rd_pend), .sel(rsel),
    .src_reg(reg_rdata), .src_frame(frame_rdata), .src_isq(isq_rdata),
    .src_ptr(ptr_val), .src_cmd(tx_cmd), .src_len(tx_len), .rdata(io_rdata)
  );

  // R10: at most one internal pulse per cycle
  a_r10_one_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_rd, reg_wr, frame_rd, frame_wr, isq_rd}));
  // R8: read data returned on the clock after the read pulse
  a_r8_rd_latency: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> (io_rdata == $past(reg_rdata)));
  // R3: constant bits of a returned pointer value
  a_r3_ro_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_pend && rsel == SRC_PTR) |=> (io_rdata[PTR_W-2:FIELD_W] == RO_VAL));

endmodule

// File: tb/iowin_top_test.sv
module iowin_top_test;

  localparam logic [15:0] BASE = 16'h0300;
  localparam int NV = 26;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] io_addr = '0;
  logic        io_addr_dis = 1'b0;
  logic        io_rd_n = 1'b1, io_wr_n = 1'b1;
  logic [1:0]  io_be = 2'b11;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata, wr_data, tx_cmd, tx_len, reg_rdata;
  logic [11:0] reg_addr;
  logic        reg_rd, reg_wr, frame_rd, frame_wr, isq_rd;
  logic [15:0] frame_rdata = 16'h5AA5;
  logic [15:0] isq_rdata   = 16'h0304;

  always #4 clk = ~clk;  // 125 MHz

  // Register file model: value derived from the address presented
  assign reg_rdata = {4'hA, reg_addr};

  iowin_top #(.BASE_ADDR(BASE)) uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_addr_dis(io_addr_dis),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_be(io_be), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .wr_data(wr_data), .reg_rdata(reg_rdata), .frame_rd(frame_rd),
    .frame_wr(frame_wr), .frame_rdata(frame_rdata), .isq_rd(isq_rd),
    .isq_rdata(isq_rdata), .tx_cmd(tx_cmd), .tx_len(tx_len)
  );

  int n_vec = 0, n_bad = 0;
  int n_reg = 0, n_frm = 0, n_isq = 0;
  logic [11:0] last_addr = '0;
  logic [15:0] last_wd = '0, last_fd = '0;

  always @(negedge clk) begin
    if (reg_rd || reg_wr) begin
      n_reg++;
      last_addr = reg_addr;
      if (reg_wr) last_wd = wr_data;
    end
    if (frame_rd || frame_wr) n_frm++;
    if (frame_wr) last_fd = wr_data;
    if (isq_rd) n_isq++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io_op(input bit wr, input logic [3:0] off, input logic [1:0] be,
                       input logic [15:0] d, input bit dis, input logic [15:0] base);
    @(negedge clk);
    io_addr = base | {12'h0, off};
    io_be = be; io_wdata = d; io_addr_dis = dis;
    if (wr) io_wr_n = 1'b0; else io_rd_n = 1'b0;
    repeat (3) @(negedge clk);  // strobe held over several clocks
    io_rd_n = 1'b1; io_wr_n = 1'b1; io_addr_dis = 1'b0;
    @(negedge clk);
  endtask

  // {wr, off, be, wdata, expected read, check addr, expected addr, req}
  localparam logic [55:0] VEC [NV] = '{
    {1'b0,4'hA,2'b11,16'h0000,16'h3000,1'b0,12'h000,4'd2},  // R2 reset pointer
    {1'b1,4'hA,2'b11,16'h0123,16'h0000,1'b0,12'h000,4'd4},  // R4 full pointer write
    {1'b0,4'hA,2'b11,16'h0000,16'h3123,1'b0,12'h000,4'd3},  // R3 constant bits
    {1'b0,4'hC,2'b11,16'h0000,16'hA123,1'b1,12'h123,4'd5},  // R5 port 0 fixed
    {1'b0,4'hA,2'b11,16'h0000,16'h3123,1'b0,12'h000,4'd5},  // R5 pointer held
    {1'b0,4'hE,2'b11,16'h0000,16'hA125,1'b1,12'h125,4'd7},  // R7 port 1 fixed
    {1'b1,4'hA,2'b11,16'hFFFE,16'h0000,1'b0,12'h000,4'd3},  // R3 writes to 14..12 dropped
    {1'b0,4'hA,2'b11,16'h0000,16'hBFFE,1'b0,12'h000,4'd3},  // R3
    {1'b1,4'hC,2'b11,16'h1111,16'h0000,1'b1,12'hFFE,4'd6},  // R6 write at FFE
    {1'b0,4'hA,2'b11,16'h0000,16'hB000,1'b0,12'h000,4'd6},  // R6 wrap
    {1'b0,4'hC,2'b11,16'h0000,16'hA000,1'b1,12'h000,4'd8},  // R8 read data
    {1'b0,4'hE,2'b11,16'h0000,16'hA002,1'b1,12'h002,4'd7},  // R7 pair high word
    {1'b0,4'hA,2'b11,16'h0000,16'hB004,1'b0,12'h000,4'd7},  // R7 pair leaves P+4
    {1'b0,4'hE,2'b11,16'h0000,16'hA006,1'b1,12'h006,4'd7},  // R7 standalone port 1
    {1'b0,4'hA,2'b11,16'h0000,16'hB006,1'b0,12'h000,4'd6},  // R6
    {1'b1,4'h4,2'b11,16'h00C0,16'h0000,1'b0,12'h000,4'd9},  // R9
    {1'b1,4'h6,2'b11,16'h0040,16'h0000,1'b0,12'h000,4'd9},  // R9
    {1'b0,4'h4,2'b11,16'h0000,16'h00C0,1'b0,12'h000,4'd9},  // R9 readback
    {1'b0,4'h6,2'b11,16'h0000,16'h0040,1'b0,12'h000,4'd9},  // R9 readback
    {1'b0,4'h0,2'b11,16'h0000,16'h5AA5,1'b0,12'h000,4'd10}, // R10 frame read
    {1'b0,4'h8,2'b11,16'h0000,16'h0304,1'b0,12'h000,4'd10}, // R10 queue read
    {1'b0,4'h2,2'b11,16'h0000,16'h0000,1'b0,12'h000,4'd11}, // R11 unmapped
    {1'b1,4'hA,2'b01,16'h00FF,16'h0000,1'b0,12'h000,4'd4},  // R4 low lane
    {1'b0,4'hA,2'b11,16'h0000,16'hB0FF,1'b0,12'h000,4'd4},  // R4
    {1'b1,4'hB,2'b10,16'h0500,16'h0000,1'b0,12'h000,4'd4},  // R4 high lane, mode cleared
    {1'b0,4'hA,2'b11,16'h0000,16'h35FF,1'b0,12'h000,4'd4}   // R4
  };

  initial begin
    repeat (40000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: outputs after reset
    chk("R2 io_rdata", io_rdata, 16'h0);
    chk("R2 tx_cmd", tx_cmd, 16'h0);
    chk("R2 tx_len", tx_len, 16'h0);
    chk("R2 pulses", {reg_rd, reg_wr, frame_rd, frame_wr, isq_rd}, 5'b0);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      int pre, dexp;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      pre = n_reg;
      io_op(v[55], v[54:51], v[50:49], v[48:33], 1'b0, BASE);
      dexp = (v[54:51] == 4'hC || v[54:51] == 4'hE) ? 1 : 0;
      chk({tag, " pulse count"}, n_reg - pre, dexp);  // R1 one action per strobe
      if (!v[55]) chk({tag, " read"}, io_rdata, v[32:17]);
      if (v[16]) chk({tag, " reg_addr"}, last_addr, v[15:4]);
      if (v[55] && dexp == 1) chk({tag, " wr_data"}, last_wd, v[48:33]);
    end

    // R9: host-visible transmit registers
    chk("R9 tx_cmd", tx_cmd, 16'h00C0);
    chk("R9 tx_len", tx_len, 16'h0040);

    // R1: foreign base and address-disable are ignored
    begin
      int pre;
      io_op(1'b1, 4'hA, 2'b11, 16'h8010, 1'b0, BASE);  // auto mode, field 010
      pre = n_reg;
      io_op(1'b0, 4'hC, 2'b11, 16'h0, 1'b0, 16'h0310);
      io_op(1'b0, 4'hC, 2'b11, 16'h0, 1'b1, BASE);
      io_op(1'b1, 4'hA, 2'b11, 16'h0222, 1'b1, BASE);
      chk("R1 rejected pulses", n_reg - pre, 0);
      io_op(1'b0, 4'hA, 2'b11, 16'h0, 1'b0, BASE);
      chk("R1 pointer untouched", io_rdata, 16'hB010);
      io_op(1'b0, 4'hC, 2'b11, 16'h0, 1'b0, BASE);
      chk("R1 accepted after reject", n_reg - pre, 1);
      io_op(1'b0, 4'hA, 2'b11, 16'h0, 1'b0, BASE);
      chk("R6 single step", io_rdata, 16'hB012);
    end

    // R10: frame write pulse and data, queue pulse count
    begin
      int pf, pq;
      pf = n_frm; pq = n_isq;
      io_op(1'b1, 4'h0, 2'b11, 16'h7E7E, 1'b0, BASE);
      chk("R10 frame_wr pulses", n_frm - pf, 1);
      chk("R10 frame data", last_fd, 16'h7E7E);
      io_op(1'b0, 4'h8, 2'b11, 16'h0, 1'b0, BASE);
      chk("R10 isq_rd pulses", n_isq - pq, 1);
      io_op(1'b0, 4'h2, 2'b11, 16'h0, 1'b0, BASE);
      chk("R11 no frame pulse", n_frm - pf, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule